// File: doc/BRIEF.md
# Two-wire bus holding FIFO with transmit lock

This block sits between the data side of a two-wire (I2C) controller and its bit shifter. Software or a DMA engine writes bytes into a transmit queue and reads received bytes out of a receive queue. The shifter takes transmit bytes through a pop handshake and pushes received bytes in. Each direction raises a request level, `tx_rdy` or `rx_rdy`, once a programmable number of entries (one, two or four) can be moved. A DMA engine can therefore move data in bursts rather than byte by byte.

When the far end refuses a byte (a NACK), the block sets a sticky lock. While the lock is set, nothing more leaves the transmit queue. The transmit request keeps signalling, so a DMA engine that is already running still deposits its bytes, and they stay parked in the queue. Software resolves the lock with an explicit clear, normally given together with a transmit flush.

After reset the block works in single-register mode: one entry per direction. An enable command switches it to full queue depth.

Top module: `twi_hold_fifo`

## Requirements
- R1: After reset both levels read 0, `lock` is 0, the block is in single-register mode, `tx_rdy` is 1 and `rx_rdy` is 0.
- R2: The transmit threshold code `tx_thr` selects a count: 0 means 1 entry, 1 means 2 entries, 2 or 3 means 4 entries. `tx_rdy` is 1 exactly when the number of free transmit entries is at least that count.
- R3: `rx_rdy` is 1 exactly when the number of stored receive entries is at least the count that `rx_thr` selects, using the same coding as R2.
- R4: Both queues are first-in first-out. `sh_tx_data` shows the oldest transmit byte, and a pop takes effect on an edge where `sh_tx_req` and `sh_tx_valid` are both 1. `rd_data` shows the oldest receive byte, and `rd_req` removes it.
- R5: A write to a full transmit queue is ignored, and `wr_err` is 1 for the one cycle after it. A read from an empty receive queue is ignored, and `rd_err` is 1 for the one cycle after it.
- R6: A shifter push into a full receive queue is dropped. The stored contents and the level are unchanged.
- R7: `tx_flush` empties the transmit queue and `rx_flush` empties the receive queue, each on the next edge. A write issued in the same cycle as `tx_flush` is discarded without raising `wr_err`.
- R8: `nack` sets `lock` on the next edge. While `lock` is 1, `sh_tx_valid` is 0 and no byte leaves the transmit queue. Writes are still accepted, and `tx_rdy` still follows the free count.
- R9: Only `lock_clr` clears `lock`; when `nack` and `lock_clr` arrive together, `nack` wins. A clear without a flush lets the held bytes leave in their original order.
- R10: In single-register mode each queue holds one entry and both thresholds act as 1. `fifo_en_cmd` selects full depth and `fifo_dis_cmd` selects single-register mode. Either command empties both queues.
- R11: `tx_level` and `rx_level` report the current entry count of each queue in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en_cmd | input | 1 | Pulse: select full queue depth, empty both queues |
| fifo_dis_cmd | input | 1 | Pulse: select single-register mode, empty both queues |
| tx_thr | input | 2 | Transmit ready threshold code |
| rx_thr | input | 2 | Receive ready threshold code |
| wr_valid | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host write byte |
| rd_req | input | 1 | Host read strobe, removes the oldest receive byte |
| rd_data | output | 8 | Oldest receive byte |
| tx_flush | input | 1 | Pulse: empty the transmit queue |
| rx_flush | input | 1 | Pulse: empty the receive queue |
| lock_clr | input | 1 | Pulse: clear the transmit lock |
| nack | input | 1 | Pulse: the far end refused a byte |
| sh_tx_req | input | 1 | Shifter requests the next transmit byte |
| sh_tx_valid | output | 1 | A transmit byte may be taken |
| sh_tx_data | output | 8 | Oldest transmit byte |
| sh_rx_valid | input | 1 | Shifter pushes a received byte |
| sh_rx_data | input | 8 | Received byte |
| tx_rdy | output | 1 | Transmit request level |
| rx_rdy | output | 1 | Receive request level |
| lock | output | 1 | Transmit lock status |
| tx_level | output | 4 | Transmit entry count |
| rx_level | output | 4 | Receive entry count |
| wr_err | output | 1 | One-cycle flag: a write was refused |
| rd_err | output | 1 | One-cycle flag: a read found nothing |

## Verification
The assertions check these rules on every cycle:
- a NACK always locks on the next edge;
- the lock persists until a clear arrives;
- the transmit count never falls while locked, unless a flush or mode command intervenes;
- counts stay at one or below in single-register mode;
- a refused write always raises its flag;
- each queue's count moves by exactly one per accepted operation.

The threshold behaviour needs the bench's sweeps over every code and every fill level, in both modes. Ordering of bytes through the queues also needs the bench. So do three further behaviours, which only show in scenario sequences: held bytes leave intact after a clear, a flush wins over a same-cycle write, and a mode change empties both queues.

// File: rtl/twi_fifo_pkg.sv
package twi_fifo_pkg;

    typedef enum logic [1:0] {
        THR_ONE      = 2'd0,
        THR_TWO      = 2'd1,
        THR_FOUR     = 2'd2,
        THR_FOUR_ALT = 2'd3
    } thr_code_e;

    // Entry count that a threshold code stands for.
    function automatic int unsigned thr_entries(input logic [1:0] code);
        case (thr_code_e'(code))
            THR_ONE: return 1;
            THR_TWO: return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/twi_fifo_ring.sv
module twi_fifo_ring #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned DW    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic [DW-1:0]                push_data,
    input  logic                         pop,
    output logic [DW-1:0]                head,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            rd_ptr;
        logic [AW-1:0]            wr_ptr;
        logic [CW-1:0]            cnt;
    } ring_t;

    ring_t ring_d, ring_q;

    always_comb begin
        ring_d = ring_q;
        if (clr) begin
            ring_d.rd_ptr = '0;
            ring_d.wr_ptr = '0;
            ring_d.cnt    = '0;
        end else begin
            if (push) begin
                ring_d.mem[ring_q.wr_ptr] = push_data;
                ring_d.wr_ptr             = ring_q.wr_ptr + 1'b1;
            end
            if (pop) begin
                ring_d.rd_ptr = ring_q.rd_ptr + 1'b1;
            end
            ring_d.cnt = ring_q.cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ring_q <= '0;
        else        ring_q <= ring_d;
    end

    assign head  = ring_q.mem[ring_q.rd_ptr];
    assign count = ring_q.cnt;

    // R4: an accepted push alone grows the count by exactly one
    a_r4_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clr) |=> (count == $past(count) + 1'b1));

    // R4: an accepted pop alone shrinks the count by exactly one
    a_r4_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !clr) |=> (count == $past(count) - 1'b1));

    // R5: the caller never pops an empty ring
    a_r5_no_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));

endmodule

// File: rtl/twi_rdy_level.sv
module twi_rdy_level
    import twi_fifo_pkg::*;
#(
    parameter int unsigned DEPTH      = 8,
    parameter bit          COUNT_FREE = 1'b1
) (
    input  logic [1:0]                 thr_code,
    input  logic                       fifo_en,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       rdy
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [CW:0] need;
    logic [CW:0] cap;
    logic [CW:0] avail;

    always_comb begin
        need = fifo_en ? (CW+1)'(thr_entries(thr_code)) : (CW+1)'(1);
        cap  = fifo_en ? (CW+1)'(DEPTH) : (CW+1)'(1);
    end

    generate
        if (COUNT_FREE) begin : g_free
            assign avail = cap - {1'b0, count};
        end else begin : g_fill
            assign avail = {1'b0, count};
        end
    endgenerate

    assign rdy = (avail >= need);

endmodule

// File: rtl/twi_hold_fifo.sv
module twi_hold_fifo
    import twi_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned DW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fifo_en_cmd,
    input  logic                       fifo_dis_cmd,
    input  logic [1:0]                 tx_thr,
    input  logic [1:0]                 rx_thr,
    input  logic                       wr_valid,
    input  logic [DW-1:0]              wr_data,
    input  logic                       rd_req,
    output logic [DW-1:0]              rd_data,
    input  logic                       tx_flush,
    input  logic                       rx_flush,
    input  logic                       lock_clr,
    input  logic                       nack,
    input  logic                       sh_tx_req,
    output logic                       sh_tx_valid,
    output logic [DW-1:0]              sh_tx_data,
    input  logic                       sh_rx_valid,
    input  logic [DW-1:0]              sh_rx_data,
    output logic                       tx_rdy,
    output logic                       rx_rdy,
    output logic                       lock,
    output logic [$clog2(DEPTH+1)-1:0] tx_level,
    output logic [$clog2(DEPTH+1)-1:0] rx_level,
    output logic                       wr_err,
    output logic                       rd_err
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic en;
        logic lock;
        logic wr_err;
        logic rd_err;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [CW-1:0] tx_cnt, rx_cnt, cap;
    logic          mode_cmd, tx_clr, rx_clr;
    logic          tx_full, rx_full;
    logic          tx_push, tx_pop, rx_push, rx_pop;

    always_comb begin
        cap      = ctrl_q.en ? CW'(DEPTH) : CW'(1);
        mode_cmd = fifo_en_cmd | fifo_dis_cmd;
        tx_clr   = tx_flush | mode_cmd;
        rx_clr   = rx_flush | mode_cmd;
        tx_full  = (tx_cnt >= cap);
        rx_full  = (rx_cnt >= cap);

        sh_tx_valid = !ctrl_q.lock && (tx_cnt != '0);
        tx_push     = wr_valid && !tx_full;
        tx_pop      = sh_tx_req && sh_tx_valid;
        rx_push     = sh_rx_valid && !rx_full;
        rx_pop      = rd_req && (rx_cnt != '0);

        ctrl_d        = ctrl_q;
        ctrl_d.wr_err = wr_valid && tx_full && !tx_clr;
        ctrl_d.rd_err = rd_req && (rx_cnt == '0) && !rx_clr;
        if (fifo_en_cmd)       ctrl_d.en = 1'b1;
        else if (fifo_dis_cmd) ctrl_d.en = 1'b0;
        if (nack)              ctrl_d.lock = 1'b1;
        else if (lock_clr)     ctrl_d.lock = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    twi_fifo_ring #(.DEPTH(DEPTH), .DW(DW)) u_tx_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (tx_clr),
        .push      (tx_push),
        .push_data (wr_data),
        .pop       (tx_pop),
        .head      (sh_tx_data),
        .count     (tx_cnt)
    );

    twi_fifo_ring #(.DEPTH(DEPTH), .DW(DW)) u_rx_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (rx_clr),
        .push      (rx_push),
        .push_data (sh_rx_data),
        .pop       (rx_pop),
        .head      (rd_data),
        .count     (rx_cnt)
    );

    twi_rdy_level #(.DEPTH(DEPTH), .COUNT_FREE(1'b1)) u_tx_rdy (
        .thr_code (tx_thr),
        .fifo_en  (ctrl_q.en),
        .count    (tx_cnt),
        .rdy      (tx_rdy)
    );

    twi_rdy_level #(.DEPTH(DEPTH), .COUNT_FREE(1'b0)) u_rx_rdy (
        .thr_code (rx_thr),
        .fifo_en  (ctrl_q.en),
        .count    (rx_cnt),
        .rdy      (rx_rdy)
    );

    assign lock     = ctrl_q.lock;
    assign wr_err   = ctrl_q.wr_err;
    assign rd_err   = ctrl_q.rd_err;
    assign tx_level = tx_cnt;
    assign rx_level = rx_cnt;

    // R8: a NACK locks the transmit path on the next edge
    a_r8_nack_locks: assert property (@(posedge clk) disable iff (!rst_n)
        nack |=> lock);

    // R9: the lock persists until a clear arrives
    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !lock_clr) |=> lock);

    // R8: while locked the transmit count never falls without a flush
    a_r8_locked_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !tx_flush && !fifo_en_cmd && !fifo_dis_cmd)
            |=> (tx_level >= $past(tx_level)));

    // R5: a write into a full queue raises the error flag
    a_r5_full_write_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && tx_full && !tx_flush && !fifo_en_cmd && !fifo_dis_cmd) |=> wr_err);

    // R10: single-register mode never holds more than one entry
    a_r10_single_entry: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q.en |-> (tx_level <= CW'(1) && rx_level <= CW'(1)));

    // R3: the receive request never asserts on an empty queue
    a_r3_rx_rdy_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rdy |-> (rx_level != '0));

endmodule

// File: tb/twi_hold_fifo_bench.sv
module twi_hold_fifo_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en_cmd = 0, fifo_dis_cmd = 0;
    logic [1:0] tx_thr = 0, rx_thr = 0;
    logic       wr_valid = 0;
    logic [7:0] wr_data = 0;
    logic       rd_req = 0;
    logic [7:0] rd_data;
    logic       tx_flush = 0, rx_flush = 0, lock_clr = 0, nack = 0;
    logic       sh_tx_req = 0;
    logic       sh_tx_valid;
    logic [7:0] sh_tx_data;
    logic       sh_rx_valid = 0;
    logic [7:0] sh_rx_data = 0;
    logic       tx_rdy, rx_rdy, lock, wr_err, rd_err;
    logic [3:0] tx_level, rx_level;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    twi_hold_fifo u_twi_hold_fifo (
        .clk(clk), .rst_n(rst_n),
        .fifo_en_cmd(fifo_en_cmd), .fifo_dis_cmd(fifo_dis_cmd),
        .tx_thr(tx_thr), .rx_thr(rx_thr),
        .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_req(rd_req), .rd_data(rd_data),
        .tx_flush(tx_flush), .rx_flush(rx_flush),
        .lock_clr(lock_clr), .nack(nack),
        .sh_tx_req(sh_tx_req), .sh_tx_valid(sh_tx_valid), .sh_tx_data(sh_tx_data),
        .sh_rx_valid(sh_rx_valid), .sh_rx_data(sh_rx_data),
        .tx_rdy(tx_rdy), .rx_rdy(rx_rdy), .lock(lock),
        .tx_level(tx_level), .rx_level(rx_level),
        .wr_err(wr_err), .rd_err(rd_err)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int need(input int code);
        return (code == 0) ? 1 : (code == 1) ? 2 : 4;
    endfunction

    task automatic wr_byte(input logic [7:0] b);
        wr_valid = 1; wr_data = b; tick(); wr_valid = 0;
    endtask

    task automatic rx_byte(input logic [7:0] b);
        sh_rx_valid = 1; sh_rx_data = b; tick(); sh_rx_valid = 0;
    endtask

    task automatic pop_tx(input logic [7:0] exp, input string req);
        check(sh_tx_valid == 1, req, sh_tx_valid, 1);
        check(sh_tx_data == exp, req, sh_tx_data, exp);
        sh_tx_req = 1; tick(); sh_tx_req = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        check(tx_level == 0, "R1", tx_level, 0);
        check(rx_level == 0, "R1", rx_level, 0);
        check(lock == 0, "R1", lock, 0);
        check(tx_rdy == 1, "R1", tx_rdy, 1);
        check(rx_rdy == 0, "R1", rx_rdy, 0);

        // R10 single-register mode: threshold acts as 1
        tx_thr = 2; rx_thr = 2;
        #1;
        check(tx_rdy == 1, "R10", tx_rdy, 1);
        wr_byte(8'h11);
        check(tx_level == 1, "R10", tx_level, 1);
        check(tx_rdy == 0, "R10", tx_rdy, 0);
        wr_byte(8'h12);
        check(wr_err == 1, "R10", wr_err, 1);
        check(tx_level == 1, "R10", tx_level, 1);
        tick();
        check(wr_err == 0, "R5", wr_err, 0);
        pop_tx(8'h11, "R10");
        check(tx_level == 0, "R10", tx_level, 0);
        rx_byte(8'h21);
        check(rx_rdy == 1, "R10", rx_rdy, 1);
        rx_byte(8'h22);
        check(rx_level == 1, "R6", rx_level, 1);
        check(rd_data == 8'h21, "R6", rd_data, 8'h21);

        // enabling empties both queues
        fifo_en_cmd = 1; tick(); fifo_en_cmd = 0;
        check(rx_level == 0, "R10", rx_level, 0);

        // R2 transmit threshold sweep
        for (int t = 0; t < 4; t++) begin
            tx_thr = 2'(t);
            tx_flush = 1; tick(); tx_flush = 0;
            for (int l = 0; l <= 8; l++) begin
                check(tx_level == 4'(l), "R11", tx_level, l);
                check(tx_rdy == ((8 - l) >= need(t)), "R2", tx_rdy, ((8 - l) >= need(t)));
                if (l < 8) wr_byte(8'(t * 16 + l));
            end
        end
        wr_byte(8'hEE);
        check(wr_err == 1, "R5", wr_err, 1);
        check(tx_level == 8, "R5", tx_level, 8);
        for (int i = 0; i < 8; i++) pop_tx(8'(48 + i), "R4");
        check(tx_level == 0, "R4", tx_level, 0);
        check(sh_tx_valid == 0, "R4", sh_tx_valid, 0);

        // R3 receive threshold sweep
        for (int t = 0; t < 4; t++) begin
            rx_thr = 2'(t);
            rx_flush = 1; tick(); rx_flush = 0;
            for (int l = 0; l <= 8; l++) begin
                check(rx_level == 4'(l), "R11", rx_level, l);
                check(rx_rdy == (l >= need(t)), "R3", rx_rdy, (l >= need(t)));
                if (l < 8) rx_byte(8'(t * 16 + 128 + l));
            end
        end
        rx_byte(8'hFF);
        check(rx_level == 8, "R6", rx_level, 8);
        for (int i = 0; i < 8; i++) begin
            check(rd_data == 8'(176 + i), "R4", rd_data, 176 + i);
            rd_req = 1; tick(); rd_req = 0;
        end
        check(rx_level == 0, "R4", rx_level, 0);
        rd_req = 1; tick(); rd_req = 0;
        check(rd_err == 1, "R5", rd_err, 1);
        check(rx_level == 0, "R5", rx_level, 0);

        // R7 flush beats a same-cycle write
        wr_byte(8'h01); wr_byte(8'h02);
        tx_flush = 1; wr_valid = 1; wr_data = 8'h03; tick();
        tx_flush = 0; wr_valid = 0;
        check(tx_level == 0, "R7", tx_level, 0);
        check(wr_err == 0, "R7", wr_err, 0);
        rx_byte(8'h05);
        rx_flush = 1; tick(); rx_flush = 0;
        check(rx_level == 0, "R7", rx_level, 0);

        // R8 lock holds queued data
        tx_thr = 1;
        wr_byte(8'hA0); wr_byte(8'hA1); wr_byte(8'hA2);
        nack = 1; tick(); nack = 0;
        check(lock == 1, "R8", lock, 1);
        check(sh_tx_valid == 0, "R8", sh_tx_valid, 0);
        sh_tx_req = 1;
        tick(); tick();
        check(tx_level == 3, "R8", tx_level, 3);
        wr_byte(8'hA3); wr_byte(8'hA4);
        sh_tx_req = 0;
        check(tx_level == 5, "R8", tx_level, 5);
        check(tx_rdy == 1, "R8", tx_rdy, 1);
        // R9 nack wins over clear
        nack = 1; lock_clr = 1; tick(); nack = 0; lock_clr = 0;
        check(lock == 1, "R9", lock, 1);
        lock_clr = 1; tick(); lock_clr = 0;
        check(lock == 0, "R9", lock, 0);
        for (int i = 0; i < 5; i++) pop_tx(8'(160 + i), "R9");
        // clear with flush
        wr_byte(8'hB0);
        nack = 1; tick(); nack = 0;
        lock_clr = 1; tx_flush = 1; tick(); lock_clr = 0; tx_flush = 0;
        check(lock == 0, "R9", lock, 0);
        check(tx_level == 0, "R9", tx_level, 0);

        // R10 disable empties both queues
        wr_byte(8'hC0); rx_byte(8'hC1);
        fifo_dis_cmd = 1; tick(); fifo_dis_cmd = 0;
        check(tx_level == 0, "R10", tx_level, 0);
        check(rx_level == 0, "R10", rx_level, 0);
        wr_byte(8'hC2); wr_byte(8'hC3);
        check(wr_err == 1, "R10", wr_err, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule